// File: doc/BRIEF.md
# Stream Word Buffer with Quantised Fill Status

This block sits between the peripheral port and the memory port of one DMA stream and holds up to sixteen 32-bit words. A producer pushes words on one side and a consumer takes them from the other. The oldest word is always shown on the read data output, so the consumer sees it before it pops. A coarse fill code tells software and the stream controller roughly how full the buffer is. A drain request rises once the fill reaches a selectable fraction of the depth. Pushing into a full buffer or popping an empty one is flagged on an error output.

An 8-bit configuration input chooses how the block behaves. When the mode bit is clear, storage is bypassed and every pushed word appears directly on the read side in the same cycle. The stored contents and the fill count are left as they were, so the buffer can be resumed later.

Top module: `dwf_word_fifo`

## Requirements
- R1: While reset is asserted and directly after it, the fill code is 3'b100, the drain request and the error output are low, and in buffered mode the output-valid flag is low.
- R2: In buffered mode (cfg_i bit 2 = 1) the words leave in the order they were pushed. The output-valid flag is high whenever at least one word is stored, and pop_data_o always shows the oldest stored word.
- R3: In every mode the fill code reports the number of stored words n out of a depth of 16: 3'b100 for n = 0, 3'b101 for n = 16, 3'b000 for 1..3, 3'b001 for 4..7, 3'b010 for 8..11 and 3'b011 for 12..15.
- R4: In buffered mode the drain request is high exactly while n >= 4·(s+1), where s is cfg_i[1:0] (0 selects 4, 1 selects 8, 2 selects 12, 3 selects 16). In pass-through mode it is low.
- R5: In pass-through mode (cfg_i bit 2 = 0), pop_data_o equals push_data_i and the output-valid flag equals push_i within the same cycle. Pushes and pops leave the stored words and the fill count unchanged.
- R6: In buffered mode, a push while n = 16 or a pop while n = 0 raises fifo_err_o for exactly the one cycle after that clock edge, but only if cfg_i bit 7 = 1. With bit 7 = 0 the output stays low.
- R7: In a cycle that raises an error condition, neither the push nor the pop takes effect, and the stored words and the count stay as they were.
- R8: cfg_i bits 6 to 3 have no effect on any output.
- R9: A push and a pop in the same cycle while 0 < n < 16 both take effect. The count stays the same and the order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8 | Bit 7 error enable, bit 2 buffered mode, bits 1:0 threshold select |
| push_i | input | 1 | Push a word this cycle |
| push_data_i | input | 32 | Word to push |
| pop_i | input | 1 | Pop the oldest word this cycle |
| pop_data_o | output | 32 | Oldest stored word, or push_data_i in pass-through |
| out_valid_o | output | 1 | Read side holds a valid word |
| level_code_o | output | 3 | Quantised fill code |
| thresh_req_o | output | 1 | Fill at or above the selected threshold |
| fifo_err_o | output | 1 | One-cycle overflow/underflow flag |

## Verification
The hardest situation to reach is an error cycle on a full buffer followed by proof that nothing was lost or duplicated. It takes sixteen pushes, then a rejected seventeenth, and only a complete drain shows that the contents survived. The bench does this for every threshold setting, and at each level it compares the code and the request against the arithmetic expectation. It also stores words and switches to pass-through, then returns to buffered mode, so the stored words have to come out intact.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
    typedef enum logic [2:0] {
        LVL_BAND0 = 3'b000,
        LVL_BAND1 = 3'b001,
        LVL_BAND2 = 3'b010,
        LVL_BAND3 = 3'b011,
        LVL_EMPTY = 3'b100,
        LVL_FULL  = 3'b101
    } lvl_code_e;

    localparam logic [7:0] CFG_ERR_EN   = 8'h80;
    localparam logic [7:0] CFG_BUFFERED = 8'h04;
    localparam logic [7:0] CFG_THR_SEL  = 8'h03;
    localparam logic [7:0] CFG_WRITABLE = CFG_ERR_EN | CFG_BUFFERED | CFG_THR_SEL;
endpackage

// File: rtl/dwf_store.sv
module dwf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/dwf_level.sv
module dwf_level
    import dwf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int QUART = DEPTH / 4
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    thr_sel,
    input  logic          buffered,
    output lvl_code_e     code,
    output logic          req
);
    logic [CW:0]   thr;
    logic [CW-1:0] band;

    always_comb begin
        // threshold is (sel + 1) quarters of the depth
        thr  = (CW+1)'(thr_sel) * (CW+1)'(QUART) + (CW+1)'(QUART);
        band = count / CW'(QUART);
        req  = buffered && ({1'b0, count} >= thr);
        if (count == '0) begin
            code = LVL_EMPTY;
        end else if (count == CW'(DEPTH)) begin
            code = LVL_FULL;
        end else begin
            code = lvl_code_e'({1'b0, band[1:0]});
        end
    end
endmodule

// File: rtl/dwf_word_fifo.sv
module dwf_word_fifo
    import dwf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              out_valid_o,
    output logic [2:0]        level_code_o,
    output logic              thresh_req_o,
    output logic              fifo_err_o
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          err;
    } state_t;

    state_t st_d, st_q;

    logic              buffered, err_en;
    logic [1:0]        thr_sel;
    logic              full, empty, bad, do_push, do_pop;
    logic [DATA_W-1:0] rd_data;
    lvl_code_e         code;

    always_comb begin
        // only the writable bits survive the mask
        buffered = ((cfg_i & CFG_WRITABLE & CFG_BUFFERED) != '0);
        err_en   = ((cfg_i & CFG_WRITABLE & CFG_ERR_EN) != '0);
        thr_sel  = 2'(cfg_i & CFG_WRITABLE & CFG_THR_SEL);

        full    = (st_q.count == CW'(DEPTH));
        empty   = (st_q.count == '0);
        bad     = buffered && ((push_i && full) || (pop_i && empty));
        do_push = buffered && push_i && !bad;
        do_pop  = buffered && pop_i && !bad;

        st_d = st_q;
        if (do_push) begin
            st_d.wr_ptr = st_q.wr_ptr + AW'(1);
        end
        if (do_pop) begin
            st_d.rd_ptr = st_q.rd_ptr + AW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + CW'(1);
            2'b01:   st_d.count = st_q.count - CW'(1);
            default: st_d.count = st_q.count;
        endcase
        st_d.err = bad && err_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dwf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (do_push),
        .wr_addr (st_q.wr_ptr),
        .wr_data (push_data_i),
        .rd_addr (st_q.rd_ptr),
        .rd_data (rd_data)
    );

    dwf_level #(.DEPTH(DEPTH)) u_level (
        .count    (st_q.count),
        .thr_sel  (thr_sel),
        .buffered (buffered),
        .code     (code),
        .req      (thresh_req_o)
    );

    assign level_code_o = code;
    assign pop_data_o   = buffered ? rd_data : push_data_i;
    assign out_valid_o  = buffered ? !empty : push_i;
    assign fifo_err_o   = st_q.err;
endmodule

// File: rtl/dwf_checker.sv
module dwf_checker
    import dwf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_i,
    input logic       push_i,
    input logic       pop_i,
    input logic [2:0] level_code_o,
    input logic       thresh_req_o,
    input logic       fifo_err_o
);
    logic buf_m, err_m, thr_full;
    assign buf_m    = ((cfg_i & CFG_BUFFERED) != '0);
    assign err_m    = ((cfg_i & CFG_ERR_EN) != '0);
    assign thr_full = ((cfg_i & CFG_THR_SEL) == CFG_THR_SEL);

    // R6: an error pulse must follow a rejected operation with the enable set
    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err_o |-> ($past(err_m) && $past(buf_m) &&
            (($past(push_i) && $past(level_code_o) == 3'b101) ||
             ($past(pop_i) && $past(level_code_o) == 3'b100))));

    // R7: a push alone into a full buffer leaves it full
    a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_m && push_i && !pop_i && level_code_o == 3'b101) |=> level_code_o == 3'b101);

    // R7: a pop alone from an empty buffer leaves it empty
    a_r7_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_m && pop_i && !push_i && level_code_o == 3'b100) |=> level_code_o == 3'b100);

    // R4: the full threshold asserts the request only when full
    a_r4_full_thr: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_m && thr_full && thresh_req_o) |-> level_code_o == 3'b101);

    // R5: pass-through cycles leave the fill untouched
    a_r5_direct_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_m |=> $stable(level_code_o));

    // R5: no drain request in pass-through
    a_r5_direct_noreq: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_m |-> !thresh_req_o);
endmodule

bind dwf_word_fifo dwf_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg_i),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .level_code_o (level_code_o),
    .thresh_req_o (thresh_req_o),
    .fifo_err_o   (fifo_err_o)
);

// File: tb/sim_dwf_word_fifo.sv
module sim_dwf_word_fifo;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_i;
    logic        push_i, pop_i;
    logic [31:0] push_data_i;
    logic [31:0] pop_data_o;
    logic        out_valid_o, thresh_req_o, fifo_err_o;
    logic [2:0]  level_code_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] q[$];
    logic  err_exp = 1'b0;
    string cur_tag = "R2";

    always #5 clk = ~clk;

    dwf_word_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .push_i(push_i),
        .push_data_i(push_data_i), .pop_i(pop_i), .pop_data_o(pop_data_o),
        .out_valid_o(out_valid_o), .level_code_o(level_code_o),
        .thresh_req_o(thresh_req_o), .fifo_err_o(fifo_err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_code(input int n);
        if (n == 0) return 32'd4;
        if (n == 16) return 32'd5;
        return 32'(n / 4);
    endfunction

    task automatic step(input logic ps, input logic pp, input logic [31:0] d, input logic [7:0] cfg);
        logic fm, bad, err_n;
        int   n;
        push_i = ps; pop_i = pp; push_data_i = d; cfg_i = cfg;
        #1;
        fm = cfg[2];
        n  = q.size();
        chk("R3", 32'(level_code_o), exp_code(n));
        chk("R4", 32'(thresh_req_o), 32'(fm && (n >= 4 * (int'(cfg[1:0]) + 1))));
        chk("R6", 32'(fifo_err_o), 32'(err_exp));
        if (fm) begin
            chk(cur_tag, 32'(out_valid_o), 32'(n != 0));
            if (n != 0) chk(cur_tag, pop_data_o, q[0]);
        end else begin
            chk("R5", 32'(out_valid_o), 32'(ps));
            chk("R5", pop_data_o, d);
        end
        bad   = fm && ((ps && n == 16) || (pp && n == 0));
        err_n = bad && cfg[7];
        @(posedge clk);
        if (fm && !bad) begin
            if (pp) void'(q.pop_front());
            if (ps) q.push_back(d);
        end
        err_exp = err_n;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        rst_n = 1'b0; cfg_i = 8'h04; push_i = 1'b0; pop_i = 1'b0; push_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", 32'(level_code_o), 32'd4);
        chk("R1", 32'(thresh_req_o), 32'd0);
        chk("R1", 32'(fifo_err_o), 32'd0);
        chk("R1", 32'(out_valid_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(level_code_o), 32'd4);
        chk("R1", 32'(out_valid_o), 32'd0);

        // fill past full and drain past empty for each threshold (R2 R3 R4 R6 R7)
        for (int t = 0; t < 4; t++) begin
            cur_tag = "R2";
            for (int i = 0; i < 17; i++) step(1'b1, 1'b0, 32'(t * 256 + i + 32'hA000), 8'h84 | 8'(t));
            step(1'b1, 1'b1, 32'hDEAD, 8'h84 | 8'(t));
            cur_tag = "R7";
            for (int i = 0; i < 18; i++) step(1'b0, 1'b1, 32'h0, 8'h84 | 8'(t));
            step(1'b1, 1'b1, 32'hBEEF, 8'h84 | 8'(t));
            step(1'b0, 1'b0, 32'h0, 8'h84 | 8'(t));
        end

        // R6: error enable cleared, underflow and overflow stay silent
        cur_tag = "R6";
        step(1'b0, 1'b1, 32'h0, 8'h04);
        step(1'b0, 1'b0, 32'h0, 8'h04);
        for (int i = 0; i < 17; i++) step(1'b1, 1'b0, 32'(i + 32'h6000), 8'h07);
        step(1'b0, 1'b0, 32'h0, 8'h07);
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 32'h0, 8'h04);

        // R8: reserved bits set in buffered and pass-through settings
        cur_tag = "R8";
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 32'(i + 32'h8000), 8'hFD);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 32'(i + 32'h9000), 8'h78);
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 32'h0, 8'h7E);

        // R9: mixed push/pop pattern from a bench LFSR
        cur_tag = "R9";
        lfsr = 8'h5B;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] | (q.size() < 3 ? 1'b1 : 1'b0), lfsr[1], 32'(i * 7 + 32'hC00), 8'h84 | {6'b0, lfsr[3:2]});
        end
        while (q.size() > 0) step(1'b0, 1'b1, 32'h0, 8'h86);

        // R5: pass-through with stored words, then resume buffered drain
        cur_tag = "R2";
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 32'(i + 32'hE000), 8'h84);
        for (int i = 0; i < 8; i++) step(i[0], i[1], 32'(i + 32'hF100), 8'h80 | 8'(i % 4));
        step(1'b0, 1'b1, 32'h0, 8'h80);
        cur_tag = "R5";
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 32'h0, 8'h84);
        step(1'b0, 1'b0, 32'h0, 8'h84);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule